// File: doc/BRIEF.md
# Variable-Page-Size Fully Associative TLB

This block holds a set of address translations and answers one lookup per clock. Every entry pairs a tag (virtual page number plus a 13-bit address-space context) with a translation word. The translation word carries a 2-bit page size, so one entry can map 8 KB, 64 KB, 512 KB or 4 MB, and the compare for that entry ignores the virtual-address bits below its own page boundary. An entry can be marked global, which makes it match in every context.

A lookup gives a virtual address, a context, the access kind and whether the access is made in user mode. One cycle later the block reports a hit with a 41-bit page-aligned physical address, a miss, a write-protection fault or a data-access fault. On any fault it fills a fault status register, a fault address register and a tag access register. On a miss only the tag access register changes, so a refill handler can read the page number and context that missed. Software loads entries through a write port and can read an entry back through a read port. Replacement choice and refill are left to the surrounding logic.

Top module: `tlb_top`

## Requirements
- R1: After reset, rsp_valid is 0, fsr, far and tag_access are 0, and every entry reads back through the read port as 0, which means invalid.
- R2: The translation word has valid at bit 63. A lookup hits an entry when valid is set, when the virtual address equals the tag's address bits above the page boundary, and when either the global bit (bit 0) is set or tag[12:0] equals the request context. rsp_valid and the result appear on the clock edge after req_valid.
- R3: Size field bits [62:61] give a page of 8 KB, 64 KB, 512 KB or 4 MB for the values 0 to 3. The page boundary is bit 13+3*size. On a hit rsp_pa takes the translation-word bits [40:13] above that boundary and the request address bits below it, and rsp_pa[12:0] is 0.
- R4: When several entries match, the entry with the lowest index supplies the result.
- R5: A miss gives rsp_kind 1 and rsp_pa 0. It loads tag_access with {va[63:13], context} and leaves fsr and far unchanged.
- R6: The data-fault flags are as follows. A user access to a page with the privileged bit (bit 2) set sets fsr[5]. A non-faulting load (kind 2) to a page with the side-effect bit (bit 3) set sets fsr[6]. A load or a store to a page with the no-fault-only bit (bit 60) set sets fsr[7]. Any of these flags gives rsp_kind 3, and more than one of them may be set at once.
- R7: A store (kind 1) with no data fault to a page whose writable bit (bit 1) is clear gives rsp_kind 2. It sets fsr[3] and leaves fsr[7:5] clear.
- R8: On a fault of either class, fsr is rewritten as follows. Bit 0 (valid) is set. Bit 1 (overflow) is set when bit 0 was already set. Bit 2 copies req_priv. Bit 3 marks a store and bit 4 marks a non-faulting load. far takes the request address and tag_access is loaded as in R5.
- R9: A hit with no fault sets the used bit (bit 4) of the winning entry. A faulting lookup leaves the used bit unchanged.
- R10: fsr_clear zeroes fsr at the next edge. A fault in the same cycle sees the register already cleared, so it does not set overflow.
- R11: A write through the write port takes effect for lookups from the next cycle on. It overrides a used-bit update to the same entry in the same cycle. rd_tte returns entry rd_idx one cycle after rd_idx is given.
- R12: A hit gives rsp_kind 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | 6 | Entry to write |
| wr_tag | input | 64 | Tag: VA[63:13], context[12:0] |
| wr_tte | input | 64 | Translation word |
| rd_idx | input | 6 | Entry to read back |
| rd_tte | output | 64 | Registered translation word of rd_idx |
| req_valid | input | 1 | Lookup request |
| req_va | input | 64 | Virtual address |
| req_ctx | input | 13 | Context of the access |
| req_kind | input | 2 | 0 load, 1 store, 2 non-faulting load |
| req_user | input | 1 | Access made in user mode |
| req_priv | input | 1 | CPU privileged state, recorded in fsr on a fault |
| fsr_clear | input | 1 | Clear the fault status register |
| rsp_valid | output | 1 | Result valid |
| rsp_kind | output | 2 | 0 hit, 1 miss, 2 protection, 3 data fault |
| rsp_pa | output | 41 | Physical address on hit |
| fsr | output | 8 | Fault status register |
| far | output | 64 | Fault address register |
| tag_access | output | 64 | Tag of last miss or fault |

## Verification
The hardest case to reach is a lookup that several entries of different page sizes match in the same cycle, combined with the fault flags and the overflow history. The stimulus therefore places a 4 MB entry over a smaller 8 KB entry, and a duplicate of an existing mapping at a higher index, and checks that the lower index wins. Faults are then issued back to back without a clear, so the overflow bit is set. After that a clear and a fault are given in the same cycle, and a write and a hit are made to one entry in the same cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 64;
  localparam int CTX_W  = 13;
  localparam int PA_W   = 41;
  localparam int PG_LSB = 13;
  localparam int TTE_W  = 64;
  localparam int FSR_W  = 8;

  // translation word fields
  localparam int TTE_VALID = 63;
  localparam int TTE_SZ_HI = 62;
  localparam int TTE_SZ_LO = 61;
  localparam int TTE_NFO   = 60;
  localparam int TTE_USED  = 4;
  localparam int TTE_SE    = 3;
  localparam int TTE_PRIV  = 2;
  localparam int TTE_WR    = 1;
  localparam int TTE_GLB   = 0;

  // fault status fields
  localparam int FSR_VLD   = 0;
  localparam int FSR_OVF   = 1;
  localparam int FSR_PRV   = 2;
  localparam int FSR_ST    = 3;
  localparam int FSR_NFA   = 4;
  localparam int FSR_FPRIV = 5;
  localparam int FSR_FSE   = 6;
  localparam int FSR_FNFO  = 7;

  typedef enum logic [1:0] {
    ACC_LOAD   = 2'd0,
    ACC_STORE  = 2'd1,
    ACC_NFLOAD = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    RSP_HIT    = 2'd0,
    RSP_MISS   = 2'd1,
    RSP_PROT   = 2'd2,
    RSP_DFAULT = 2'd3
  } rsp_e;

  // keep-mask for a page of the given size: zero below bit 13+3*size
  function automatic logic [VA_W-1:0] size_mask(input logic [1:0] sz);
    logic [6:0] sh;
    sh = 7'(PG_LSB) + {5'd0, sz} + {5'd0, sz} + {5'd0, sz};
    return ~(({{(VA_W-1){1'b0}}, 1'b1} << sh) - {{(VA_W-1){1'b0}}, 1'b1});
  endfunction
endpackage

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
  import tlb_pkg::*;
#(
  parameter int AW = VA_W,
  parameter int CW = CTX_W
) (
  input  logic [AW-1:0] tag,
  input  logic          valid,
  input  logic          global_pg,
  input  logic [1:0]    size,
  input  logic [AW-1:0] va,
  input  logic [CW-1:0] ctx,
  output logic          match
);
  logic va_ok;
  logic ctx_ok;

  // low CW bits of the tag hold the context; the mask clears them
  assign va_ok  = ((va ^ tag) & size_mask(size)) == '0;
  assign ctx_ok = global_pg || (tag[CW-1:0] == ctx);
  assign match  = valid && va_ok && ctx_ok;
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/tlb_fault_eval.sv
module tlb_fault_eval
  import tlb_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       user,
  input  logic       pg_priv,
  input  logic       pg_se,
  input  logic       pg_nfo,
  input  logic       pg_wr,
  output logic       f_priv,
  output logic       f_se,
  output logic       f_nfo,
  output logic       dfault,
  output logic       prot
);
  logic is_nf;
  logic is_st;

  assign is_nf  = kind == ACC_NFLOAD;
  assign is_st  = kind == ACC_STORE;
  assign f_priv = pg_priv && user;
  assign f_se   = is_nf && pg_se;
  assign f_nfo  = !is_nf && pg_nfo;
  assign dfault = f_priv || f_se || f_nfo;
  assign prot   = !dfault && is_st && !pg_wr;
endmodule

// File: rtl/tlb_top.sv
module tlb_top
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VA_W-1:0]  wr_tag,
  input  logic [TTE_W-1:0] wr_tte,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TTE_W-1:0] rd_tte,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  input  logic [CTX_W-1:0] req_ctx,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  input  logic             req_priv,
  input  logic             fsr_clear,
  output logic             rsp_valid,
  output logic [1:0]       rsp_kind,
  output logic [PA_W-1:0]  rsp_pa,
  output logic [FSR_W-1:0] fsr,
  output logic [VA_W-1:0]  far,
  output logic [VA_W-1:0]  tag_access
);
  logic [VA_W-1:0]  tag_q [ENTRIES];
  logic [TTE_W-1:0] tte_q [ENTRIES];
  logic [ENTRIES-1:0] match_v;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic             f_priv, f_se, f_nfo, dfault, prot;
  logic [PA_W-1:0]  sel_mask;
  logic [PA_W-1:0]  pa_next;
  logic [FSR_W-1:0] fsr_eff;
  logic [FSR_W-1:0] fsr_fault;
  logic [VA_W-1:0]  tac_next;

  // one comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    tlb_entry_cmp #(.AW(VA_W), .CW(CTX_W)) u_cmp (
      .tag       (tag_q[g]),
      .valid     (tte_q[g][TTE_VALID]),
      .global_pg (tte_q[g][TTE_GLB]),
      .size      (tte_q[g][TTE_SZ_HI:TTE_SZ_LO]),
      .va        (req_va),
      .ctx       (req_ctx),
      .match     (match_v[g])
    );
  end

  tlb_prio_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_prio (
    .req (match_v),
    .any (hit),
    .idx (hit_idx)
  );

  tlb_fault_eval u_fault (
    .kind    (req_kind),
    .user    (req_user),
    .pg_priv (tte_q[hit_idx][TTE_PRIV]),
    .pg_se   (tte_q[hit_idx][TTE_SE]),
    .pg_nfo  (tte_q[hit_idx][TTE_NFO]),
    .pg_wr   (tte_q[hit_idx][TTE_WR]),
    .f_priv  (f_priv),
    .f_se    (f_se),
    .f_nfo   (f_nfo),
    .dfault  (dfault),
    .prot    (prot)
  );

  assign sel_mask = PA_W'(size_mask(tte_q[hit_idx][TTE_SZ_HI:TTE_SZ_LO]));
  assign pa_next  = ((tte_q[hit_idx][PA_W-1:0] & sel_mask) |
                     (req_va[PA_W-1:0] & ~sel_mask)) &
                    {{(PA_W-PG_LSB){1'b1}}, {PG_LSB{1'b0}}};
  assign tac_next = {req_va[VA_W-1:CTX_W], req_ctx};
  assign fsr_eff  = fsr_clear ? '0 : fsr;

  always_comb begin
    fsr_fault            = '0;
    fsr_fault[FSR_VLD]   = 1'b1;
    fsr_fault[FSR_OVF]   = fsr_eff[FSR_VLD];
    fsr_fault[FSR_PRV]   = req_priv;
    fsr_fault[FSR_ST]    = req_kind == ACC_STORE;
    fsr_fault[FSR_NFA]   = req_kind == ACC_NFLOAD;
    fsr_fault[FSR_FPRIV] = f_priv;
    fsr_fault[FSR_FSE]   = f_se;
    fsr_fault[FSR_FNFO]  = f_nfo;
  end

  // entry storage: used-bit update first so a write to the same entry wins
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        tte_q[i] <= '0;
      end
      rd_tte <= '0;
    end else begin
      if (req_valid && hit && !dfault && !prot)
        tte_q[hit_idx][TTE_USED] <= 1'b1;
      if (wr_en) begin
        tag_q[wr_idx] <= wr_tag;
        tte_q[wr_idx] <= wr_tte;
      end
      rd_tte <= tte_q[rd_idx];
    end
  end

  // response and fault registers
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_kind   <= RSP_HIT;
      rsp_pa     <= '0;
      fsr        <= '0;
      far        <= '0;
      tag_access <= '0;
    end else begin
      rsp_valid <= req_valid;
      fsr       <= fsr_eff;
      if (req_valid) begin
        rsp_pa <= '0;
        if (!hit) begin
          rsp_kind   <= RSP_MISS;
          tag_access <= tac_next;
        end else if (dfault || prot) begin
          rsp_kind   <= dfault ? RSP_DFAULT : RSP_PROT;
          fsr        <= fsr_fault;
          far        <= req_va;
          tag_access <= tac_next;
        end else begin
          rsp_kind <= RSP_HIT;
          rsp_pa   <= pa_next;
        end
      end
    end
  end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker
  import tlb_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             fsr_clear,
  input logic             rsp_valid,
  input logic [1:0]       rsp_kind,
  input logic [PA_W-1:0]  rsp_pa,
  input logic [FSR_W-1:0] fsr,
  input logic [VA_W-1:0]  far
);
  // R2: one result per request, one cycle later
  a_r2_resp_latency: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R3: physical address is page aligned
  a_r3_pa_aligned: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_pa[PG_LSB-1:0] == '0);

  // R5: a miss keeps the status and fault address
  a_r5_miss_keeps_status: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == RSP_MISS && !$past(fsr_clear)) |->
      (fsr == $past(fsr) && far == $past(far)));

  // R7: protection faults carry no data-fault flags and mark a store
  a_r7_prot_flags: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == RSP_PROT) |->
      (fsr[FSR_FNFO:FSR_FPRIV] == '0 && fsr[FSR_ST]));

  // R6: a data fault has at least one flag
  a_r6_dfault_flag: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == RSP_DFAULT) |->
      fsr[FSR_FNFO:FSR_FPRIV] != '0);

  // R8: every fault leaves valid status; repeated faults set overflow
  a_r8_fault_valid: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind[1]) |-> fsr[FSR_VLD]);
  a_r8_overflow: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind[1] && $past(fsr[FSR_VLD]) && !$past(fsr_clear))
      |-> fsr[FSR_OVF]);

  // R10: a clear with no request empties the status
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    (fsr_clear && !req_valid) |=> fsr == '0);
endmodule

bind tlb_top tlb_checker u_tlb_checker (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .fsr_clear (fsr_clear),
  .rsp_valid (rsp_valid),
  .rsp_kind  (rsp_kind),
  .rsp_pa    (rsp_pa),
  .fsr       (fsr),
  .far       (far)
);

// File: tb/tb_tlb_top.sv
module tb_tlb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [63:0] wr_tag = '0;
  logic [63:0] wr_tte = '0;
  logic [5:0]  rd_idx = '0;
  logic [63:0] rd_tte;
  logic        req_valid = 1'b0;
  logic [63:0] req_va = '0;
  logic [12:0] req_ctx = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0;
  logic        req_priv = 1'b0;
  logic        fsr_clear = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_kind;
  logic [40:0] rsp_pa;
  logic [7:0]  fsr;
  logic [63:0] far;
  logic [63:0] tag_access;

  tlb_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_tte(wr_tte), .rd_idx(rd_idx), .rd_tte(rd_tte), .req_valid(req_valid),
    .req_va(req_va), .req_ctx(req_ctx), .req_kind(req_kind),
    .req_user(req_user), .req_priv(req_priv), .fsr_clear(fsr_clear),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_pa(rsp_pa), .fsr(fsr),
    .far(far), .tag_access(tag_access)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  logic [63:0] m_tag [64];
  logic [63:0] m_tte [64];
  logic [7:0]  m_fsr;
  logic [63:0] m_far, m_tac, m_rd;
  logic        m_rv;
  logic [1:0]  m_rk;
  logic [40:0] m_pa;

  task automatic chk(string rq, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, got, exp);
    end
  endtask

  function automatic logic [63:0] mk_tte(logic [63:0] pa, int sz, bit nfo, bit se,
                                         bit pr, bit w, bit gl);
    logic [63:0] t;
    t = (64'd1 << 63) | (64'(sz) << 61) | (pa & 64'h1FF_FFFF_E000);
    if (nfo) t = t | (64'd1 << 60);
    if (se)  t = t | 64'd8;
    if (pr)  t = t | 64'd4;
    if (w)   t = t | 64'd2;
    if (gl)  t = t | 64'd1;
    return t;
  endfunction

  // one clock: drive, predict, compare all outputs
  task automatic step(string rq);
    int hi;
    int sh;
    logic [63:0] mask, used_set;
    logic [7:0] fe, nf;
    bit fp, fs, fn, pf;
    logic [63:0] pfull;
    hi = -1;
    used_set = 0;
    m_rd = m_tte[rd_idx];
    fe = fsr_clear ? 8'h00 : m_fsr;
    m_rv = req_valid;
    m_fsr = fe;
    if (req_valid) begin
      m_pa = '0;
      for (int i = 0; i < 64; i++) begin
        if (hi < 0 && m_tte[i][63]) begin
          sh = 13 + 3 * int'(m_tte[i][62:61]);
          mask = ~((64'd1 << sh) - 64'd1);
          if (((req_va & mask) == (m_tag[i] & mask)) &&
              (m_tte[i][0] || m_tag[i][12:0] == req_ctx)) hi = i;
        end
      end
      if (hi < 0) begin
        m_rk = 2'd1;
        m_tac = {req_va[63:13], req_ctx};
      end else begin
        fp = m_tte[hi][2] && req_user;
        fs = (req_kind == 2'd2) && m_tte[hi][3];
        fn = (req_kind != 2'd2) && m_tte[hi][60];
        pf = !(fp || fs || fn) && req_kind == 2'd1 && !m_tte[hi][1];
        if (fp || fs || fn || pf) begin
          m_rk = (fp || fs || fn) ? 2'd3 : 2'd2;
          nf = 8'h01;
          if (fe[0]) nf[1] = 1;
          if (req_priv) nf[2] = 1;
          if (req_kind == 2'd1) nf[3] = 1;
          if (req_kind == 2'd2) nf[4] = 1;
          if (fp) nf[5] = 1;
          if (fs) nf[6] = 1;
          if (fn) nf[7] = 1;
          m_fsr = nf;
          m_far = req_va;
          m_tac = {req_va[63:13], req_ctx};
        end else begin
          m_rk = 2'd0;
          sh = 13 + 3 * int'(m_tte[hi][62:61]);
          mask = ~((64'd1 << sh) - 64'd1);
          pfull = ((m_tte[hi] & mask) | (req_va & ~mask)) & 64'h1FF_FFFF_E000;
          m_pa = pfull[40:0];
          used_set = 64'd1 << hi;
        end
      end
    end
    @(posedge clk);
    for (int i = 0; i < 64; i++) if (used_set[i]) m_tte[i][4] = 1'b1;
    if (wr_en) begin
      m_tag[wr_idx] = wr_tag;
      m_tte[wr_idx] = wr_tte;
    end
    @(negedge clk);
    chk(rq, "rsp_valid", 64'(rsp_valid), 64'(m_rv));
    if (m_rv) begin
      chk(rq, "rsp_kind", 64'(rsp_kind), 64'(m_rk));
      chk(rq, "rsp_pa", 64'(rsp_pa), 64'(m_pa));
    end
    chk(rq, "fsr", 64'(fsr), 64'(m_fsr));
    chk(rq, "far", far, m_far);
    chk(rq, "tag_access", tag_access, m_tac);
    chk(rq, "rd_tte", rd_tte, m_rd);
    wr_en = 0;
    req_valid = 0;
    fsr_clear = 0;
  endtask

  task automatic wr(string rq, int idx, logic [63:0] tg, logic [63:0] tt);
    wr_en = 1; wr_idx = 6'(idx); wr_tag = tg; wr_tte = tt;
    step(rq);
  endtask

  task automatic look(string rq, logic [63:0] va, logic [12:0] cx, logic [1:0] kd,
                      bit us, bit pv);
    req_valid = 1; req_va = va; req_ctx = cx; req_kind = kd;
    req_user = us; req_priv = pv;
    step(rq);
  endtask

  task automatic rd(string rq, int idx);
    rd_idx = 6'(idx);
    step(rq);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_tag[i] = '0; m_tte[i] = '0; end
    m_fsr = '0; m_far = '0; m_tac = '0; m_rd = '0; m_rv = 0; m_rk = 0; m_pa = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd_idx = 6'd5;
    step("R1");
    rd("R1", 63);

    // R11 entries written through the port and read back
    wr("R11", 0,  64'h0000_0040_0000_2000 | 64'd5, mk_tte(64'h1_2345_6000, 0, 0, 0, 0, 1, 0));
    wr("R11", 1,  64'h0000_0000_0081_0000 | 64'd9, mk_tte(64'h0_0AB0_0000, 1, 0, 0, 0, 1, 1));
    wr("R11", 2,  64'h0000_0000_0300_0000 | 64'd5, mk_tte(64'h1_0008_0000, 2, 0, 0, 0, 0, 0));
    wr("R11", 3,  64'hFFFF_FFFF_0040_0000 | 64'd5, mk_tte(64'h1_F0C0_0000, 3, 0, 0, 0, 1, 0));
    wr("R11", 4,  64'h0000_0010_0000_0000 | 64'd5, mk_tte(64'h0_0100_0000, 0, 0, 0, 1, 1, 0));
    wr("R11", 5,  64'h0000_0010_0000_2000 | 64'd5, mk_tte(64'h0_0100_2000, 0, 0, 1, 0, 1, 0));
    wr("R11", 6,  64'h0000_0010_0000_4000 | 64'd5, mk_tte(64'h0_0100_4000, 0, 1, 0, 0, 1, 0));
    wr("R11", 7,  64'h0000_0010_0000_6000 | 64'd5, mk_tte(64'h0_0100_6000, 0, 1, 0, 1, 1, 0));
    wr("R11", 9,  64'h2000_0000_0012_4000 | 64'd5, mk_tte(64'h0_0777_0000, 0, 0, 0, 0, 1, 0));
    wr("R11", 10, 64'h2000_0000_0000_0000 | 64'd5, mk_tte(64'h1_8000_0000, 3, 0, 0, 0, 1, 0));
    wr("R11", 11, 64'h0000_0050_0000_0000 | 64'd5, mk_tte(64'h0_0200_0000, 0, 0, 0, 0, 1, 0) & ~(64'd1 << 63));
    wr("R11", 20, 64'h0000_0040_0000_2000 | 64'd5, mk_tte(64'h0_0999_0000, 0, 0, 0, 0, 1, 0));
    rd("R11", 3);

    // R2, R12 hits with context and global
    look("R2",  64'h0000_0040_0000_2ABC, 13'd5, 2'd0, 1, 0);
    look("R12", 64'h0000_0000_0081_FABC, 13'd3, 2'd0, 1, 0);
    look("R2",  64'h0000_0050_0000_0010, 13'd5, 2'd0, 0, 0); // invalid entry: miss
    // R5 miss on context mismatch
    look("R5",  64'h0000_0040_0000_2ABC, 13'd6, 2'd0, 1, 0);
    // R3 page sizes
    look("R3",  64'h0000_0000_0307_5123, 13'd5, 2'd0, 0, 0);
    look("R3",  64'hFFFF_FFFF_007A_BCDE, 13'd5, 2'd0, 0, 0);
    look("R3",  64'h0000_0000_0081_0000, 13'd0, 2'd1, 0, 0);
    // R4 lowest index wins
    look("R4",  64'h2000_0000_0012_4ABC, 13'd5, 2'd0, 0, 0);
    look("R4",  64'h2000_0000_0033_0000, 13'd5, 2'd0, 0, 0);
    look("R4",  64'h0000_0040_0000_3FFF, 13'd5, 2'd0, 0, 0);
    // R6 data faults
    look("R6",  64'h0000_0010_0000_0100, 13'd5, 2'd0, 1, 0);
    look("R6",  64'h0000_0010_0000_2100, 13'd5, 2'd2, 0, 1);
    look("R6",  64'h0000_0010_0000_4100, 13'd5, 2'd1, 0, 0);
    look("R6",  64'h0000_0010_0000_6100, 13'd5, 2'd0, 1, 0);
    look("R6",  64'h0000_0010_0000_4100, 13'd5, 2'd2, 0, 0); // NF load on no-fault-only page: hit
    look("R6",  64'h0000_0010_0000_0100, 13'd5, 2'd0, 0, 0); // kernel on privileged page: hit
    // R7 protection
    look("R7",  64'h0000_0000_0300_0040, 13'd5, 2'd1, 0, 1);
    look("R7",  64'h0000_0040_0000_2040, 13'd5, 2'd1, 0, 0);
    // R5 miss keeps fsr/far after faults
    look("R5",  64'h0000_0077_0000_0000, 13'd7, 2'd0, 0, 0);
    // R10 clear alone, then clear with fault
    fsr_clear = 1; step("R10");
    look("R8",  64'h0000_0010_0000_0200, 13'd5, 2'd0, 1, 1);
    fsr_clear = 1;
    look("R10", 64'h0000_0010_0000_6200, 13'd5, 2'd1, 1, 0);
    // R8 overflow on second fault
    look("R8",  64'h0000_0000_0300_0000, 13'd5, 2'd1, 0, 1);
    // R9 used bit
    rd("R9", 0);
    rd("R9", 7);
    rd("R9", 2);
    rd("R9", 9);
    // R11 write and hit on same entry in same cycle: write wins
    wr_en = 1; wr_idx = 6'd6; wr_tag = 64'h0000_0010_0000_4000 | 64'd5;
    wr_tte = mk_tte(64'h0_0300_4000, 0, 0, 0, 0, 1, 0);
    look("R11", 64'h0000_0010_0000_4000, 13'd5, 2'd2, 0, 0);
    rd("R11", 6);
    look("R11", 64'h0000_0010_0000_4000, 13'd5, 2'd0, 0, 0);
    rd("R9", 6);
    step("R2");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule